// File: doc/BRIEF.md
# Programmable Watchdog Timeout Timer

This block supervises a host processor attached to a real-time-clock peripheral. The host loads an 8-bit control byte through a plain register-write strobe. Five bits of that byte form a multiplier, and two bits choose a time base. The product sets how long the host may stay silent. Time is counted in periods of a 16 Hz tick-enable supplied by the clock's own timebase. Every write to the control byte starts the interval again. If the interval runs out, the block raises a sticky watchdog flag and an interrupt level.

The flag goes low when the host reads the flags register. The interrupt level is released only by writing 00h, which also disarms the timer. The interrupt shares one output pin with a frequency-test signal. While the timer is armed and no square-wave output is enabled, the watchdog owns the pin and the test request is refused.

Top module: `wdt_watchdog`

## Requirements
- R1: After synchronous reset the control byte is 00h, the timer is disarmed, and both `wd_flag` and `wd_irq` are low.
- R2: Bits 6:2 of the control byte are the multiplier M and bits 1:0 are the resolution code. Code 0 is 1 tick, code 1 is 4 ticks, code 2 is 16 ticks and code 3 is 64 ticks. The timeout is M times that count. `wd_irq` rises on the clock edge that samples the timeout-th tick counted after the last write.
- R3: Any write to the control byte resets the tick count to zero. A tick presented in the same cycle as a write is not counted.
- R4: On expiry, `wd_flag` and `wd_irq` both go high on the next clock edge.
- R5: A write of exactly 00h drops `wd_irq` on the next edge and disarms the timer, so no expiry follows however many ticks arrive.
- R6: A pulse on `flags_rd` clears `wd_flag`, but an expiry in the same cycle wins. `wd_irq` stays high after the read until 00h is written, and a nonzero write does not release it.
- R7: A control byte whose multiplier field is zero leaves the timer disarmed, whatever the resolution code.
- R8: Bit 7 of the control byte has no effect on the timeout.
- R9: After an expiry the count halts. No further expiry occurs, and the flag stays clear after a read, until the next write.
- R10: The frequency test is active when `ftest_req` is 1 and `sqw_en` is 0. If the timer is armed at that point, `ftest_blocked` is 1 and `pin_out` follows `wd_irq`. If the timer is disarmed, `pin_out` follows `ftest_wave`. In every other case `pin_out` follows `wd_irq` and `ftest_blocked` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16_en | input | 1 | One-cycle 16 Hz tick enable |
| wr_en | input | 1 | Control-byte write strobe |
| wr_data | input | 8 | Control-byte write value |
| flags_rd | input | 1 | Flags-register read strobe |
| ftest_req | input | 1 | Frequency-test request |
| sqw_en | input | 1 | Square-wave output enable |
| ftest_wave | input | 1 | Frequency-test waveform |
| wd_flag | output | 1 | Watchdog flag (flags register bit 7) |
| wd_irq | output | 1 | Watchdog interrupt level |
| pin_out | output | 1 | Shared interrupt / test pin |
| ftest_blocked | output | 1 | Frequency test refused by watchdog |

## Verification
The timeout is swept over all four resolution codes with multipliers 1, 2, 7 and 31. Each run checks that `wd_irq` is still low one tick before the expected count and high on it, which separates the tick counts per code and the field positions. Further patterns cover:
- a restart part-way through the interval;
- a spare bit 7;
- a zero multiplier with a nonzero code;
- a read colliding with expiry;
- the three combinations of pin ownership.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int REG_W    = 8;
    localparam int MULT_W   = 5;
    localparam int RES_W    = 2;
    localparam int MAX_SHFT = 6;
    localparam int CNT_W    = MULT_W + MAX_SHFT;

    typedef enum logic [RES_W-1:0] {
        RES_TICK1  = 2'd0,
        RES_TICK4  = 2'd1,
        RES_TICK16 = 2'd2,
        RES_TICK64 = 2'd3
    } res_e;

    typedef struct packed {
        logic              spare;
        logic [MULT_W-1:0] mult;
        res_e              res;
    } wdt_cfg_t;

    // number of ticks for one unit of the selected resolution
    function automatic logic [CNT_W-1:0] res_ticks(input res_e r);
        logic [CNT_W-1:0] one;
        one = CNT_W'(1);
        return one << (2 * int'(r));
    endfunction

    // total timeout in ticks: multiplier times resolution
    function automatic logic [CNT_W-1:0] timeout_ticks(input wdt_cfg_t c);
        logic [CNT_W-1:0] m;
        m = CNT_W'(c.mult);
        return m << (2 * int'(c.res));
    endfunction

endpackage

// File: rtl/wdt_cfg_reg.sv
module wdt_cfg_reg
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output wdt_cfg_t         cfg,
    output logic             armed,
    output logic             restart,
    output logic             clear_req
);
    wdt_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            cfg_q <= wdt_cfg_t'(wr_data);
        end
    end

    always_comb begin
        cfg       = cfg_q;
        armed     = (cfg_q.mult != '0);
        restart   = wr_en;
        clear_req = wr_en && (wr_data == '0);
    end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             restart,
    input  logic             armed,
    input  logic [CNT_W-1:0] limit,
    output logic             expire,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] cnt_q;
    logic             done_q;
    logic             step;
    logic             at_end;

    always_comb begin
        step   = armed && !done_q && tick_en && !restart;
        at_end = (cnt_q == (limit - CNT_W'(1)));
        expire = step && at_end;
        count  = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (restart) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (step) begin
            cnt_q <= cnt_q + CNT_W'(1);
            if (at_end) begin
                done_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/wdt_flag_irq.sv
module wdt_flag_irq (
    input  logic clk,
    input  logic rst,
    input  logic expire,
    input  logic flags_rd,
    input  logic clear_req,
    output logic wd_flag,
    output logic wd_irq
);
    logic flag_q;
    logic irq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            if (expire) begin
                flag_q <= 1'b1;
            end else if (flags_rd) begin
                flag_q <= 1'b0;
            end
            if (clear_req) begin
                irq_q <= 1'b0;
            end else if (expire) begin
                irq_q <= 1'b1;
            end
        end
    end

    assign wd_flag = flag_q;
    assign wd_irq  = irq_q;
endmodule

// File: rtl/wdt_pin_mux.sv
module wdt_pin_mux (
    input  logic armed,
    input  logic ftest_req,
    input  logic sqw_en,
    input  logic ftest_wave,
    input  logic wd_irq,
    output logic pin_out,
    output logic ftest_blocked
);
    logic ftest_want;
    logic ftest_owns;

    always_comb begin
        ftest_want    = ftest_req && !sqw_en;
        ftest_owns    = ftest_want && !armed;
        ftest_blocked = ftest_want && armed;
        pin_out       = ftest_owns ? ftest_wave : wd_irq;
    end
endmodule

// File: rtl/wdt_watchdog.sv
module wdt_watchdog
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick16_en,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             flags_rd,
    input  logic             ftest_req,
    input  logic             sqw_en,
    input  logic             ftest_wave,
    output logic             wd_flag,
    output logic             wd_irq,
    output logic             pin_out,
    output logic             ftest_blocked
);
    wdt_cfg_t         cfg;
    logic             armed;
    logic             restart;
    logic             clear_req;
    logic [CNT_W-1:0] limit;
    logic             expire_p;
    logic [CNT_W-1:0] count_q;

    wdt_cfg_reg cfg_i (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .cfg       (cfg),
        .armed     (armed),
        .restart   (restart),
        .clear_req (clear_req)
    );

    assign limit = timeout_ticks(cfg);

    wdt_counter cnt_i (
        .clk     (clk),
        .rst     (rst),
        .tick_en (tick16_en),
        .restart (restart),
        .armed   (armed),
        .limit   (limit),
        .expire  (expire_p),
        .count   (count_q)
    );

    wdt_flag_irq fi_i (
        .clk       (clk),
        .rst       (rst),
        .expire    (expire_p),
        .flags_rd  (flags_rd),
        .clear_req (clear_req),
        .wd_flag   (wd_flag),
        .wd_irq    (wd_irq)
    );

    wdt_pin_mux mux_i (
        .armed         (armed),
        .ftest_req     (ftest_req),
        .sqw_en        (sqw_en),
        .ftest_wave    (ftest_wave),
        .wd_irq        (wd_irq),
        .pin_out       (pin_out),
        .ftest_blocked (ftest_blocked)
    );
endmodule

// File: rtl/wdt_watchdog_chk.sv
module wdt_watchdog_chk
    import wdt_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [REG_W-1:0] wr_data,
    input logic             flags_rd,
    input logic             wd_flag,
    input logic             wd_irq,
    input logic             pin_out,
    input logic             ftest_blocked,
    input logic             expire_p,
    input logic             armed,
    input logic [CNT_W-1:0] count_q
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst |=> (!wd_flag && !wd_irq && !armed));

    // R3
    restart_zero_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (count_q == '0));

    // R4
    expire_raise_chk: assert property (@(posedge clk) disable iff (rst)
        expire_p |=> (wd_flag && wd_irq));

    // R5
    zero_write_release_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data == '0) |=> (!wd_irq && !armed));

    // R6
    read_clears_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (flags_rd && !expire_p) |=> !wd_flag);

    // R6
    irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (wd_irq && !(wr_en && wr_data == '0)) |=> wd_irq);

    // R7
    zero_mult_disarm_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[6:2] == '0) |=> !armed);

    // R10
    pin_owner_chk: assert property (@(posedge clk) disable iff (rst)
        ftest_blocked |-> (pin_out == wd_irq));
endmodule

bind wdt_watchdog wdt_watchdog_chk chk_i (
    .clk           (clk),
    .rst           (rst),
    .wr_en         (wr_en),
    .wr_data       (wr_data),
    .flags_rd      (flags_rd),
    .wd_flag       (wd_flag),
    .wd_irq        (wd_irq),
    .pin_out       (pin_out),
    .ftest_blocked (ftest_blocked),
    .expire_p      (expire_p),
    .armed         (armed),
    .count_q       (count_q)
);

// File: tb/wdt_watchdog_tb_top.sv
module wdt_watchdog_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick16_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       flags_rd = 1'b0;
    logic       ftest_req = 1'b0;
    logic       sqw_en = 1'b0;
    logic       ftest_wave = 1'b0;
    logic       wd_flag, wd_irq, pin_out, ftest_blocked;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    wdt_watchdog dut_i (
        .clk(clk), .rst(rst), .tick16_en(tick16_en), .wr_en(wr_en),
        .wr_data(wr_data), .flags_rd(flags_rd), .ftest_req(ftest_req),
        .sqw_en(sqw_en), .ftest_wave(ftest_wave), .wd_flag(wd_flag),
        .wd_irq(wd_irq), .pin_out(pin_out), .ftest_blocked(ftest_blocked)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] v);
        @(negedge clk); wr_en = 1'b1; wr_data = v;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd_flags();
        @(negedge clk); flags_rd = 1'b1;
        @(negedge clk); flags_rd = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick16_en = 1'b1;
            @(negedge clk); tick16_en = 1'b0;
        end
    endtask

    task automatic clean();
        wr(8'h00);
        rd_flags();
    endtask

    function automatic int expect_ticks(input int m, input int r);
        return m * (1 << (2 * r));
    endfunction

    initial begin
        while (cyc < 150000) begin
            @(posedge clk); cyc++;
        end
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int mults[4];
        int lim;
        mults = '{1, 2, 7, 31};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 flag", wd_flag, 0);
        chk("R1 irq", wd_irq, 0);
        chk("R1 pin", pin_out, 0);

        // R2 sweep over resolution codes and multipliers
        for (int r = 0; r < 4; r++) begin
            for (int k = 0; k < 4; k++) begin
                clean();
                lim = expect_ticks(mults[k], r);
                wr(8'((mults[k] << 2) | r));
                ticks(lim - 1);
                chk("R2 before timeout", wd_irq, 0);
                ticks(1);
                chk("R2 at timeout", wd_irq, 1);
                chk("R4 flag at timeout", wd_flag, 1);
            end
        end

        // R8 spare bit 7 ignored: 0x8E gives 3 x 16 ticks
        clean();
        wr(8'h8E);
        ticks(47);
        chk("R8 before", wd_irq, 0);
        ticks(1);
        chk("R8 at", wd_irq, 1);

        // R3 restart mid-interval
        clean();
        wr(8'h0E);
        ticks(40);
        wr(8'h0E);
        ticks(40);
        chk("R3 restarted", wd_irq, 0);
        ticks(7);
        chk("R3 one before", wd_irq, 0);
        ticks(1);
        chk("R3 expiry", wd_irq, 1);

        // R3 tick in same cycle as write is not counted
        clean();
        @(negedge clk); wr_en = 1'b1; wr_data = 8'h05; tick16_en = 1'b1;
        @(negedge clk); wr_en = 1'b0; tick16_en = 1'b0;
        ticks(3);
        chk("R3 same-cycle tick", wd_irq, 0);
        ticks(1);
        chk("R3 same-cycle expiry", wd_irq, 1);

        // R6 read clears flag, irq remains; R9 no re-expiry
        rd_flags();
        chk("R6 flag cleared", wd_flag, 0);
        chk("R6 irq held", wd_irq, 1);
        ticks(20);
        chk("R9 flag stays clear", wd_flag, 0);
        wr(8'h05);
        chk("R6 nonzero write keeps irq", wd_irq, 1);

        // R5 zero write releases and disarms
        wr(8'h00);
        chk("R5 irq released", wd_irq, 0);
        ticks(200);
        chk("R5 no expiry", wd_irq, 0);
        chk("R5 no flag", wd_flag, 0);

        // R7 zero multiplier, nonzero resolution
        clean();
        wr(8'h03);
        ticks(300);
        chk("R7 disarmed", wd_irq, 0);
        chk("R7 flag", wd_flag, 0);

        // R6 expiry and read in the same cycle: set wins
        clean();
        wr(8'h0C);
        ticks(2);
        @(negedge clk); tick16_en = 1'b1; flags_rd = 1'b1;
        @(negedge clk); tick16_en = 1'b0; flags_rd = 1'b0;
        chk("R6 set beats read", wd_flag, 1);

        // R10 pin ownership
        clean();
        wr(8'h0E);
        ftest_req = 1'b1; sqw_en = 1'b0; ftest_wave = 1'b1;
        @(negedge clk);
        chk("R10 blocked when armed", ftest_blocked, 1);
        chk("R10 pin is irq when armed", pin_out, 0);
        sqw_en = 1'b1;
        @(negedge clk);
        chk("R10 not blocked with sqw", ftest_blocked, 0);
        chk("R10 pin irq with sqw", pin_out, 0);
        sqw_en = 1'b0;
        wr(8'h00);
        chk("R10 disarmed not blocked", ftest_blocked, 0);
        chk("R10 pin follows wave", pin_out, 1);
        ftest_wave = 1'b0;
        @(negedge clk);
        chk("R10 pin follows wave low", pin_out, 0);
        ftest_req = 1'b0;

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule